// File: doc/BRIEF.md
# AES-128 Sequential Round-Key Expander

This block expands a 128-bit cipher key into the ten AES-128 round keys. It does the work one round at a time and uses one substitution table that has a registered read port. When the block is idle, a single-cycle start strobe captures the cipher key. That key is stored as entry 0 of an eleven-entry key store, and generation begins.

Each round key takes a fixed two-cycle step. In the first cycle, the block rotates the last word of the previous key by one byte and presents its four bytes to four parallel table lanes. In the second cycle, the substituted word arrives from the table. The block XORs it with the round constant and then runs the XOR chain that forms all four new words. All four words are written into the store together.

A busy flag covers the whole generation. A done flag rises when the last key is written. The stored keys can be read at any time through a read port that takes the round number as its index, and they stay unchanged until the next accepted start.

Top module: `key_expander`

## Requirements
- R1: After reset, busy_o and done_o are low and every store entry reads as zero.
- R2: A start_i that is high at a rising edge while busy_o is low is accepted. It writes key_i to entry 0, sets busy_o high and clears done_o after that edge.
- R3: After an accepted start, busy_o falls and done_o rises on the 20th rising edge, and never earlier. busy_o and done_o are never high together.
- R4: Entry n (1..10) holds the standard AES-128 round key n of the captured key. The round constants used for rounds 1..10 are 01,02,04,08,10,20,40,80,1b,36, applied to the most significant byte of the substituted word.
- R5: Word 0 of every 128-bit key sits in bits 127:96, and word 3 sits in bits 31:0.
- R6: rd_key_o shows entry rd_idx_i combinationally. Index values 11 to 15 read as zero.
- R7: start_i is ignored while busy_o is high. The running expansion and its timing are not affected.
- R8: When no start is accepted, done_o and all entries keep their values after generation ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start strobe, sampled at the rising edge |
| key_i | input | 128 | Cipher key, word 0 in bits 127:96 |
| rd_idx_i | input | 4 | Round number to read |
| rd_key_o | output | 128 | Stored key for rd_idx_i |
| busy_o | output | 1 | Generation in progress |
| done_o | output | 1 | All round keys valid |

## Verification
The assertions assume two things about the inputs: reset is applied before the first start, and start_i is a level that is sampled only at rising edges. Under those assumptions they require an exact 20-cycle busy window. They also treat a start during busy as having no effect on that window. The stimulus changes start_i, key_i and rd_idx_i only on falling edges and always lets reset release before the first strobe. It also deliberately asserts start_i in the middle of a run, so the ignore rule is exercised rather than avoided.

// File: rtl/key_exp_pkg.sv
package key_exp_pkg;

  typedef enum logic [1:0] {ST_IDLE, ST_ADDR, ST_MIX} kx_state_e;

  function automatic logic [7:0] gf_xtime(input logic [7:0] a);
    return {a[6:0], 1'b0} ^ (a[7] ? 8'h1b : 8'h00);
  endfunction

  function automatic logic [7:0] gf_mul(input logic [7:0] a, input logic [7:0] b);
    logic [7:0] acc;
    logic [7:0] sh;
    acc = 8'h00;
    sh  = a;
    for (int i = 0; i < 8; i++) begin
      if (b[i]) acc = acc ^ sh;
      sh = gf_xtime(sh);
    end
    return acc;
  endfunction

  // inverse = x^254, built as x^2 * x^4 * ... * x^128
  function automatic logic [7:0] gf_inv(input logic [7:0] x);
    logic [7:0] p;
    logic [7:0] r;
    p = x;
    r = 8'h01;
    for (int i = 1; i < 8; i++) begin
      p = gf_mul(p, p);
      r = gf_mul(r, p);
    end
    return r;
  endfunction

  function automatic logic [7:0] rotl8(input logic [7:0] v, input int n);
    return (v << n) | (v >> (8 - n));
  endfunction

  function automatic logic [7:0] sbox_f(input logic [7:0] x);
    logic [7:0] b;
    b = gf_inv(x);
    return b ^ rotl8(b, 1) ^ rotl8(b, 2) ^ rotl8(b, 3) ^ rotl8(b, 4) ^ 8'h63;
  endfunction

endpackage

// File: rtl/key_sbox_lane.sv
module key_sbox_lane
  import key_exp_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [7:0] addr_i,
  output logic [7:0] data_o
);
  // registered table: data appears one clock after address
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) data_o <= 8'h00;
    else         data_o <= sbox_f(addr_i);
  end
endmodule

// File: rtl/key_store.sv
module key_store #(
  parameter int DEPTH = 11,
  parameter int W     = 128,
  parameter int IDX_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [IDX_W-1:0] waddr_i,
  input  logic [W-1:0]     wdata_i,
  input  logic [IDX_W-1:0] raddr_i,
  output logic [W-1:0]     rdata_o
);
  logic [W-1:0] mem_q [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_ent
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                     mem_q[g] <= '0;
      else if (we_i && (waddr_i == IDX_W'(g)))         mem_q[g] <= wdata_i;
    end
  end

  always_comb begin
    rdata_o = '0;
    for (int i = 0; i < DEPTH; i++)
      if (raddr_i == IDX_W'(i)) rdata_o = mem_q[i];
  end
endmodule

// File: rtl/key_exp_ctrl.sv
module key_exp_ctrl
  import key_exp_pkg::*;
#(
  parameter int NUM_ROUNDS = 10,
  parameter int IDX_W      = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  output logic             load_o,
  output logic             mix_o,
  output logic [IDX_W-1:0] round_o,
  output logic [7:0]       rcon_o,
  output logic             busy_o,
  output logic             done_o
);
  kx_state_e        state_q;
  logic [IDX_W-1:0] round_q;
  logic [7:0]       rcon_q;
  logic             done_q;
  logic             last_round;

  assign load_o     = start_i && (state_q == ST_IDLE);
  assign mix_o      = (state_q == ST_MIX);
  assign last_round = (round_q == IDX_W'(NUM_ROUNDS));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      round_q <= '0;
      rcon_q  <= 8'h00;
      done_q  <= 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (load_o) begin
          state_q <= ST_ADDR;
          round_q <= IDX_W'(1);
          rcon_q  <= 8'h01;
          done_q  <= 1'b0;
        end
        ST_ADDR: state_q <= ST_MIX;
        ST_MIX: begin
          if (last_round) begin
            state_q <= ST_IDLE;
            done_q  <= 1'b1;
          end else begin
            state_q <= ST_ADDR;
            round_q <= round_q + IDX_W'(1);
            rcon_q  <= gf_xtime(rcon_q);
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign round_o = round_q;
  assign rcon_o  = rcon_q;
  assign busy_o  = (state_q != ST_IDLE);
  assign done_o  = done_q;
endmodule

// File: rtl/key_expander.sv
module key_expander #(
  parameter int NUM_ROUNDS = 10,
  parameter int IDX_W      = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [127:0]     key_i,
  input  logic [IDX_W-1:0] rd_idx_i,
  output logic [127:0]     rd_key_o,
  output logic             busy_o,
  output logic             done_o
);
  localparam int NWORDS = 4;
  localparam int DEPTH  = NUM_ROUNDS + 1;

  logic             load, mix;
  logic [IDX_W-1:0] round;
  logic [7:0]       rcon;
  logic [127:0]     cur_q;
  logic [31:0]      cur_w [NWORDS];
  logic [31:0]      new_w [NWORDS];
  logic [31:0]      rot_w, sub_w, tmp_w;
  logic [127:0]     next_key;
  logic             we;
  logic [IDX_W-1:0] waddr;
  logic [127:0]     wdata;

  key_exp_ctrl #(.NUM_ROUNDS(NUM_ROUNDS), .IDX_W(IDX_W)) i_ctrl (
    .clk_i, .rst_ni, .start_i,
    .load_o(load), .mix_o(mix), .round_o(round), .rcon_o(rcon),
    .busy_o, .done_o
  );

  for (genvar w = 0; w < NWORDS; w++) begin : g_word
    assign cur_w[w] = cur_q[127-32*w -: 32];
    assign next_key[127-32*w -: 32] = new_w[w];
  end

  assign rot_w = {cur_w[NWORDS-1][23:0], cur_w[NWORDS-1][31:24]};

  for (genvar b = 0; b < 4; b++) begin : g_lane
    key_sbox_lane i_lane (
      .clk_i, .rst_ni,
      .addr_i(rot_w[8*b +: 8]),
      .data_o(sub_w[8*b +: 8])
    );
  end

  assign tmp_w = sub_w ^ {rcon, 24'h0};

  always_comb begin
    new_w[0] = cur_w[0] ^ tmp_w;
    for (int i = 1; i < NWORDS; i++) new_w[i] = cur_w[i] ^ new_w[i-1];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   cur_q <= '0;
    else if (load) cur_q <= key_i;
    else if (mix)  cur_q <= next_key;
  end

  assign we    = load | mix;
  assign waddr = load ? '0 : round;
  assign wdata = load ? key_i : next_key;

  key_store #(.DEPTH(DEPTH), .W(128), .IDX_W(IDX_W)) i_store (
    .clk_i, .rst_ni,
    .we_i(we), .waddr_i(waddr), .wdata_i(wdata),
    .raddr_i(rd_idx_i), .rdata_o(rd_key_o)
  );
endmodule

// File: rtl/key_expander_chk.sv
module key_expander_chk #(
  parameter int NUM_ROUNDS = 10
) (
  input logic clk_i,
  input logic rst_ni,
  input logic start_i,
  input logic busy_o,
  input logic done_o
);
  localparam int GEN = 2 * NUM_ROUNDS;
  int unsigned cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  cnt_q <= 0;
    else if (start_i && !busy_o)  cnt_q <= 0;
    else if (busy_o)              cnt_q <= cnt_q + 1;
  end

  // R2
  start_accept_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !busy_o) |=> (busy_o && !done_o));
  // R3
  excl_flags_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(busy_o && done_o));
  // R3
  gen_len_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> (cnt_q == GEN && done_o));
  // R7
  busy_window_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> (cnt_q < GEN));
  // R8
  done_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && !start_i) |=> $stable(done_o));
endmodule

bind key_expander key_expander_chk #(.NUM_ROUNDS(NUM_ROUNDS)) i_chk (
  .clk_i, .rst_ni, .start_i, .busy_o, .done_o
);

// File: tb/test_key_expander.sv
module test_key_expander;
  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b0;
  logic         start_i = 1'b0;
  logic [127:0] key_i = '0;
  logic [3:0]   rd_idx_i = '0;
  logic [127:0] rd_key_o;
  logic         busy_o, done_o;

  int n_chk = 0;
  int n_bad = 0;

  localparam logic [127:0] FIPS_KEY = 128'h2b7e151628aed2a6abf7158809cf4f3c;

  always #10 clk_i = ~clk_i;

  key_expander i_key_expander (.*);

  function automatic logic [127:0] fips_rk(input int n);
    case (n)
      0:  return 128'h2b7e151628aed2a6abf7158809cf4f3c;
      1:  return 128'ha0fafe1788542cb123a339392a6c7605;
      2:  return 128'hf2c295f27a96b9435935807a7359f67f;
      3:  return 128'h3d80477d4716fe3e1e237e446d7a883b;
      4:  return 128'hef44a541a8525b7fb671253bdb0bad00;
      5:  return 128'hd4d1c6f87c839d87caf2b8bc11f915bc;
      6:  return 128'h6d88a37a110b3efddbf98641ca0093fd;
      7:  return 128'h4e54f70e5f5fc9f384a64fb24ea6dc4f;
      8:  return 128'head27321b58dbad2312bf5607f8d292f;
      9:  return 128'hac7766f319fadc2128d12941575c006e;
      10: return 128'hd014f9a8c9ee2589e13f0cc8b6630ca6;
      default: return '0;
    endcase
  endfunction

  task automatic check(input string req, input logic [127:0] act, input logic [127:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic pulse_start(input logic [127:0] k);
    @(negedge clk_i);
    start_i = 1'b1;
    key_i   = k;
    @(negedge clk_i);
    start_i = 1'b0;
  endtask

  task automatic wait_cycles(input int n);
    for (int i = 0; i < n; i++) @(negedge clk_i);
  endtask

  task automatic t_reset;
    check("R1 busy", 128'(busy_o), 0);
    check("R1 done", 128'(done_o), 0);
    for (int i = 0; i < 11; i++) begin
      rd_idx_i = 4'(i); #1;
      check("R1 entry", rd_key_o, '0);
    end
  endtask

  task automatic t_fips;
    pulse_start(FIPS_KEY);
    rd_idx_i = 0; #1;
    check("R2 busy", 128'(busy_o), 1);
    check("R2 entry0", rd_key_o, FIPS_KEY);
    wait_cycles(19);
    check("R3 busy before 20", 128'(busy_o), 1);
    check("R3 done before 20", 128'(done_o), 0);
    wait_cycles(1);
    check("R3 done at 20", 128'(done_o), 1);
    check("R3 busy at 20", 128'(busy_o), 0);
    for (int i = 0; i <= 10; i++) begin
      rd_idx_i = 4'(i); #1;
      check("R4 fips round key", rd_key_o, fips_rk(i));
    end
    rd_idx_i = 4'd1; #1;
    check("R5 word0 bits 127:96", 128'(rd_key_o[127:96]), 128'h a0fafe17);
  endtask

  task automatic t_range;
    for (int i = 11; i < 16; i++) begin
      rd_idx_i = 4'(i); #1;
      check("R6 out of range", rd_key_o, '0);
    end
  endtask

  task automatic t_hold;
    wait_cycles(30);
    check("R8 done held", 128'(done_o), 1);
    rd_idx_i = 4'd10; #1;
    check("R8 entry10 held", rd_key_o, fips_rk(10));
  endtask

  task automatic t_zero_key;
    pulse_start('0);
    check("R2 done cleared", 128'(done_o), 0);
    wait_cycles(20);
    check("R3 done zero key", 128'(done_o), 1);
    rd_idx_i = 4'd1; #1;
    check("R4 zero key round1", rd_key_o, 128'h62636363626363636263636362636363);
    rd_idx_i = 4'd10; #1;
    check("R4 zero key round10", rd_key_o, 128'hb4ef5bcb3e92e21123e951cf6f8f188e);
  endtask

  task automatic t_ignore;
    pulse_start(FIPS_KEY);
    wait_cycles(4);
    start_i = 1'b1; key_i = '1;
    @(negedge clk_i);
    start_i = 1'b0;
    wait_cycles(14);
    check("R7 still busy", 128'(busy_o), 1);
    wait_cycles(1);
    check("R7 done on time", 128'(done_o), 1);
    for (int i = 0; i <= 10; i++) begin
      rd_idx_i = 4'(i); #1;
      check("R7 keys unaffected", rd_key_o, fips_rk(i));
    end
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk_i);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    wait_cycles(3);
    t_reset();
    rst_ni = 1'b1;
    wait_cycles(2);
    t_fips();
    t_range();
    t_hold();
    t_zero_key();
    t_ignore();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule